// File: doc/BRIEF.md
# Lissajous Curve Plotter and Control

This block draws Lissajous figures into a one-bit-per-pixel square frame buffer. An 8-bit switch value (0 to 255) is the data for three settings: the horizontal frequency word, the vertical frequency word and the vertical phase offset. A rising edge on one of three buttons copies the switches into the chosen setting. The settings drive an external two-channel sine generator. That generator sends back signed samples on one shared bus, and each sample carries a channel tag.

Channel 0 samples give the horizontal coordinate and channel 1 samples give the vertical coordinate. A vertical sample that follows a horizontal sample completes a point. The block maps the point into the square so that a zero sample lands on the centre pixel and the full signed range spans the whole side. It then writes a 1 to that pixel through the buffer's write port. The address is `row * FIELD + column`.

A fourth button starts a clear. The clear writes 0 to every pixel in the buffer, one pixel per clock. While the clear runs, the sine generator is held in reset. When the clear ends, the generator restarts with the horizontal channel at zero phase and the vertical channel at the programmed phase.

Top module: `lissajous_plotter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `freqX`, `freqY` and `phaseY` are 0, and `wrEn` and `genReset` are low.
- R2: A rising edge on `btnRaw[0]` loads `swVal` into `freqX`. The new value is visible after the third rising clock edge that samples the pressed button. `freqY` and `phaseY` do not change.
- R3: A rising edge on `btnRaw[1]` loads `swVal` into `freqY`, and a rising edge on `btnRaw[2]` loads `swVal` into `phaseY`, with the same latency as R2.
- R4: A button that stays pressed loads only once. If `swVal` changes while the button is held, the register keeps the value it captured at the press.
- R5: A sample with `smpChan`=1 that arrives after a sample with `smpChan`=0 produces exactly one write cycle on the next clock. In that cycle `wrEn`=1, `wrData`=1 and `wrAddr` = row*FIELD + column.
- R6: A sample s of width SAMPLE_W maps to the pixel coordinate HALF + floor(s*(HALF-1) / 2^(SAMPLE_W-1)), clamped to 0..FIELD-1, where HALF = FIELD/2. A zero sample gives HALF.
- R7: A channel-1 sample with no channel-0 sample before it since the last write causes no write. When several channel-0 samples arrive in a row, the write uses the newest one.
- R8: A rising edge on `btnRaw[3]` starts a clear on the same clock edge at which R2 would load. For FIELD*FIELD cycles, `genReset`=1 and `wrEn`=1 with `wrData`=0, and `wrAddr` counts up from 0 by one each cycle. After that, `genReset` and `wrEn` return low.
- R9: Samples that arrive while a clear runs produce no plot write. A channel-0 sample taken during the clear cannot pair with a channel-1 sample that arrives after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swVal | input | 8 | Setting value from the switches |
| btnRaw | input | 4 | Raw buttons: 0 horizontal frequency, 1 vertical frequency, 2 vertical phase, 3 clear |
| smpData | input | SAMPLE_W | Signed sine sample |
| smpValid | input | 1 | Sample present this cycle |
| smpChan | input | 1 | Sample channel: 0 horizontal, 1 vertical |
| freqX | output | 8 | Horizontal frequency word |
| freqY | output | 8 | Vertical frequency word |
| phaseY | output | 8 | Vertical phase offset |
| genReset | output | 1 | Synchronous reset to the sine generator |
| wrEn | output | 1 | Frame buffer write enable |
| wrAddr | output | $clog2(FIELD*FIELD) | Frame buffer write address |
| wrData | output | 1 | Frame buffer write pixel |

## Verification
Button results (a register load or the start of a clear) arrive three clock edges after the raw input goes high: two edges for the synchronizer and one to register the result. The bench holds the button, waits exactly three rising edges, and samples on the next falling edge. A plot write is due one edge after the vertical sample is presented, so it is checked on the falling edge that follows that sample. During a clear, the address and data are compared on every falling edge against a running index until the last pixel. Two more checks then confirm that `genReset` and `wrEn` have dropped on the next falling edge.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef struct packed {
    logic ldFreqX;
    logic ldFreqY;
    logic ldPhaseY;
    logic startClear;
  } lp_cmd_t;
endpackage

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int SW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] swVal,
  input  logic [3:0]      btnRaw,
  output logic [SW_W-1:0] freqX,
  output logic [SW_W-1:0] freqY,
  output logic [SW_W-1:0] phaseY,
  output lp_cmd_t         cmd
);
  localparam int BTN_N = 4;
  localparam int REG_N = 3;

  logic [BTN_N-1:0] syncA, syncB, prevB, rise;
  logic [SW_W-1:0]  setting [REG_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= btnRaw;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign rise = syncB & ~prevB;

  assign cmd.ldFreqX    = rise[0];
  assign cmd.ldFreqY    = rise[1];
  assign cmd.ldPhaseY   = rise[2];
  assign cmd.startClear = rise[3];

  for (genvar g = 0; g < REG_N; g++) begin : g_setting
    always_ff @(posedge clk) begin
      if (rst) setting[g] <= '0;
      else if (rise[g]) setting[g] <= swVal;
    end
  end

  assign freqX  = setting[0];
  assign freqY  = setting[1];
  assign phaseY = setting[2];

  AST_LOAD_FREQ_X: assert property (@(posedge clk) disable iff (rst)
    cmd.ldFreqX |=> freqX == $past(swVal)); // R2
  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (rst)
    cmd.ldPhaseY |=> phaseY == $past(swVal)); // R3
  AST_ONE_LOAD_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
    cmd.ldFreqX |=> !cmd.ldFreqX); // R4
  AST_FREQ_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd.ldFreqY |=> $stable(freqY)); // R2
endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
#(
  parameter int FIELD    = 384,
  parameter int SAMPLE_W = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  lp_cmd_t                            cmd,
  input  logic signed [SAMPLE_W-1:0]         smpData,
  input  logic                               smpValid,
  input  logic                               smpChan,
  output logic                               genReset,
  output logic                               wrEn,
  output logic [$clog2(FIELD*FIELD)-1:0]     wrAddr,
  output logic                               wrData
);
  localparam int NPIX  = FIELD * FIELD;
  localparam int AW    = $clog2(NPIX);
  localparam int CW    = $clog2(FIELD);
  localparam int HALF  = FIELD / 2;
  localparam int SCALE = HALF - 1;

  function automatic logic [CW-1:0] toPix(input logic signed [SAMPLE_W-1:0] s);
    logic signed [31:0] p;
    p = 32'(s) * 32'(SCALE);
    p = p >>> (SAMPLE_W - 1);
    p = p + 32'(HALF);
    if (p < 0) return '0;
    else if (p > 32'(FIELD - 1)) return CW'(FIELD - 1);
    else return p[CW-1:0];
  endfunction

  logic          clearBusy;
  logic [AW-1:0] clearCnt;
  logic          haveX;
  logic [CW-1:0] xPix;
  logic          plotWr;
  logic [AW-1:0] plotAddr;
  logic          blockPlot;

  assign blockPlot = clearBusy | cmd.startClear;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearBusy <= 1'b0;
      clearCnt  <= '0;
    end else if (cmd.startClear) begin
      clearBusy <= 1'b1;
      clearCnt  <= '0;
    end else if (clearBusy) begin
      if (clearCnt == AW'(NPIX - 1)) clearBusy <= 1'b0;
      else clearCnt <= clearCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      haveX    <= 1'b0;
      xPix     <= '0;
      plotWr   <= 1'b0;
      plotAddr <= '0;
    end else begin
      plotWr <= 1'b0;
      if (blockPlot) begin
        haveX <= 1'b0;
      end else if (smpValid && !smpChan) begin
        xPix  <= toPix(smpData);
        haveX <= 1'b1;
      end else if (smpValid && smpChan && haveX) begin
        plotWr   <= 1'b1;
        plotAddr <= AW'(toPix(smpData)) * AW'(FIELD) + AW'(xPix);
        haveX    <= 1'b0;
      end
    end
  end

  assign genReset = clearBusy;
  assign wrEn     = clearBusy | plotWr;
  assign wrAddr   = clearBusy ? clearCnt : plotAddr;
  assign wrData   = !clearBusy;

  AST_PLOT_AFTER_Y: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData) |-> $past(smpValid && smpChan)); // R5
  AST_ADDR_IN_FIELD: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> wrAddr < AW'(NPIX)); // R6
  AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (clearBusy && !cmd.startClear) |=> (!clearBusy || wrAddr == AW'($past(wrAddr) + 1'b1))); // R8
  AST_NO_PLOT_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(clearBusy) |-> !(wrEn && wrData)); // R9
endmodule

// File: rtl/lissajous_plotter.sv
module lissajous_plotter
  import lp_pkg::*;
#(
  parameter int FIELD    = 384,
  parameter int SAMPLE_W = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [7:0]                     swVal,
  input  logic [3:0]                     btnRaw,
  input  logic signed [SAMPLE_W-1:0]     smpData,
  input  logic                           smpValid,
  input  logic                           smpChan,
  output logic [7:0]                     freqX,
  output logic [7:0]                     freqY,
  output logic [7:0]                     phaseY,
  output logic                           genReset,
  output logic                           wrEn,
  output logic [$clog2(FIELD*FIELD)-1:0] wrAddr,
  output logic                           wrData
);
  lp_cmd_t cmd;

  lp_ctrl #(.SW_W(8)) u_ctrl (
    .clk(clk), .rst(rst), .swVal(swVal), .btnRaw(btnRaw),
    .freqX(freqX), .freqY(freqY), .phaseY(phaseY), .cmd(cmd)
  );

  lp_datapath #(.FIELD(FIELD), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .smpData(smpData), .smpValid(smpValid), .smpChan(smpChan),
    .genReset(genReset), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!wrEn && !genReset && freqX == 8'd0)); // R1
endmodule

// File: tb/sim_lissajous_plotter.sv
module sim_lissajous_plotter;
  localparam int CLK_PERIOD = 10;
  localparam int FIELD = 24;
  localparam int SW = 10;
  localparam int NPIX = FIELD * FIELD;
  localparam int AW = $clog2(NPIX);
  localparam int NVEC = 6;
  localparam int VEC_W = 2 * SW + AW;

  // {x sample, y sample, expected address} for FIELD=24, SAMPLE_W=10
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {10'sd0,    10'sd0,    10'd300},
    {10'sd511,  -10'sd512, 10'd46},
    {-10'sd512, 10'sd511,  10'd529},
    {10'sd256,  -10'sd256, 10'd161},
    {-10'sd1,   10'sd100,  10'd347},
    {10'sd100,  -10'sd1,   10'd278}
  };

  logic clk = 0, rst = 1;
  logic [7:0] swVal = 0;
  logic [3:0] btnRaw = 0;
  logic signed [SW-1:0] smpData = 0;
  logic smpValid = 0, smpChan = 0;
  logic [7:0] freqX, freqY, phaseY;
  logic genReset, wrEn, wrData;
  logic [AW-1:0] wrAddr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lissajous_plotter #(.FIELD(FIELD), .SAMPLE_W(SW)) u0 (
    .clk(clk), .rst(rst), .swVal(swVal), .btnRaw(btnRaw),
    .smpData(smpData), .smpValid(smpValid), .smpChan(smpChan),
    .freqX(freqX), .freqY(freqY), .phaseY(phaseY),
    .genReset(genReset), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // press at a falling edge, result due after three rising edges
  task automatic press(input int b, input logic [7:0] v);
    swVal = v;
    btnRaw[b] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_all();
    btnRaw = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendSample(input logic ch, input logic signed [SW-1:0] d);
    smpValid = 1'b1; smpChan = ch; smpData = d;
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 freqX reset", freqX, 0);
    check("R1 wrEn reset", wrEn, 0);
    check("R1 genReset reset", genReset, 0);
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {freqX, freqY, phaseY, 6'b0, wrEn, genReset}, 0);

    // table-driven plotting, R5 R6
    for (int i = 0; i < NVEC; i++) begin
      sendSample(1'b0, VECS[i][VEC_W-1 -: SW]);
      check("R5 no write on X", wrEn, 0);
      sendSample(1'b1, VECS[i][VEC_W-SW-1 -: SW]);
      check("R5 write enable", {wrEn, wrData}, 2'b11);
      check("R6 address", wrAddr, VECS[i][AW-1:0]);
      @(negedge clk);
      check("R5 single write", wrEn, 0);
    end

    // R7: lone Y, and newest X used
    sendSample(1'b1, 10'sd0);
    check("R7 Y without X", wrEn, 0);
    sendSample(1'b0, 10'sd511);
    sendSample(1'b0, 10'sd0);
    sendSample(1'b1, 10'sd0);
    check("R7 newest X", wrAddr, 300);
    sendSample(1'b1, 10'sd0);
    check("R7 second Y no write", wrEn, 0);

    // R2 R3 R4
    press(0, 8'h11);
    check("R2 freqX load", freqX, 8'h11);
    check("R2 others kept", {freqY, phaseY}, 0);
    swVal = 8'h22;
    repeat (4) @(negedge clk);
    check("R4 held button", freqX, 8'h11);
    release_all();
    press(1, 8'hA5);
    check("R3 freqY load", freqY, 8'hA5);
    release_all();
    press(2, 8'h40);
    check("R3 phaseY load", phaseY, 8'h40);
    check("R3 freqX kept", freqX, 8'h11);
    release_all();

    // R8 R9: clear with samples arriving
    sendSample(1'b0, 10'sd0);
    press(3, 8'h00);
    begin
      int bad = 0;
      for (int i = 0; i < NPIX; i++) begin
        if (!(genReset && wrEn && !wrData && wrAddr == AW'(i))) begin
          if (bad == 0)
            $display("FAIL R8 clear step %0d actual=%0h expected=%0h", i, wrAddr, i);
          bad++;
        end
        smpValid = 1'b1; smpChan = i[0]; smpData = SW'(i);
        @(negedge clk);
      end
      smpValid = 1'b0;
      nChecks++;
      if (bad != 0) nFails++;
    end
    check("R8 clear end genReset", genReset, 0);
    check("R9 no write after clear", wrEn, 0);
    btnRaw = '0;
    sendSample(1'b1, 10'sd0);
    check("R9 stale X not paired", wrEn, 0);
    sendSample(1'b0, 10'sd0);
    sendSample(1'b1, 10'sd0);
    check("R5 plotting resumes", {wrEn, wrData, 6'b0, wrAddr}, {2'b11, 6'b0, AW'(300)});

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule